// File: doc/BRIEF.md
# Dual-Mode Interrupt Request Generator

This block produces the interrupt request for a key-scan controller. It drives one active-low open-drain pin through a pull-down enable. The request can come from two triggers, separately or together. The first is a countdown of debounce cycles that starts at each key event. The second is a threshold on how many events the key FIFO holds. When both are enabled, whichever trigger is met first raises the request.

A deassert-mode bit selects how the request is cleared. In one mode any FIFO read clears it. In the other mode it stays set until the FIFO reports empty.

When the whole configuration byte is zero, the interrupt function is switched off and the pin becomes a general-purpose output. It then follows a single port-register bit, where 1 leaves the pin floating and 0 pulls it low. The bus interface that writes the configuration and reads the FIFO sits outside this block. It supplies the configuration byte, the FIFO occupancy, the read strobe and the empty flag as plain inputs.

Top module: `irq_req_gen`

## Requirements
- R1: After reset, with a nonzero configuration byte and no trigger met, `irq_od_en` is 0 (pin not pulled low).
- R2: With `cfg_byte` equal to 0x00, `irq_od_en` equals the inverse of `gpo_level`: a level of 1 means high impedance (`irq_od_en`=0) and 0 means driven low (`irq_od_en`=1).
- R3: While `cfg_byte` is 0x00, key events, debounce ticks and FIFO occupancy have no effect on the pin, and no request is pending when a nonzero configuration is then applied.
- R4: With `cfg_byte[4:0]` = N (1..31), the request asserts on the N-th `db_tick` after a `key_event` pulse and is visible on `irq_od_en` from the clock edge that samples that tick. It does not assert before that tick.
- R5: A new `key_event` restarts the countdown from N. When a key event and a tick come in the same cycle, the event wins and that tick is not counted.
- R6: After the countdown fires it stops, and further ticks raise no request until the next key event.
- R7: With `cfg_byte[4:0]` = 0, key events and ticks never raise a request.
- R8: With `cfg_byte[7:5]` = M (1..7), the request asserts on the clock edge at which `fifo_count` is first at or above 2×M, after having been below it. With M = 0 the FIFO level never raises a request.
- R9: With both fields nonzero, the request asserts on whichever trigger occurs first, and the other trigger can set it again later.
- R10: With `clr_on_empty` = 0, a `fifo_rd` pulse clears the request at the next clock edge.
- R11: With `clr_on_empty` = 1, `fifo_rd` does not clear the request. It clears on the clock edge that samples `fifo_empty` = 1.
- R12: A trigger and a clear condition in the same cycle leave the request asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_byte | input | DLY_W+LVL_W | Interrupt configuration: [4:0] delay in debounce cycles, [7:5] FIFO level / 2 |
| fifo_count | input | OCC_W | Number of events held in the key FIFO |
| key_event | input | 1 | One-cycle pulse per debounced key event |
| db_tick | input | 1 | One-cycle pulse at the end of each debounce cycle |
| fifo_rd | input | 1 | One-cycle pulse per FIFO read |
| fifo_empty | input | 1 | FIFO holds no events |
| clr_on_empty | input | 1 | Deassert mode: 0 clears on read, 1 clears on empty |
| gpo_level | input | 1 | Port-register bit used in general-purpose output mode |
| irq_od_en | output | 1 | Open-drain enable; 1 pulls the pin low |

## Verification
The bench builds the block with its default parameters: a 5-bit delay field, a 3-bit level field and a 5-bit occupancy. At these sizes the full configuration byte is in play. Every delay from 1 to 31 is swept tick by tick, and every level setting from 1 to 7 is swept through the occupancy values around its threshold. Expected results come from simple arithmetic on N and 2×M. Directed cases then cover countdown restarts, same-cycle collisions, both clear modes and the switch into and out of general-purpose output mode.

// File: rtl/irq_req_pkg.sv
package irq_req_pkg;

  localparam int unsigned DEF_DLY_W = 5;
  localparam int unsigned DEF_LVL_W = 3;
  localparam int unsigned DEF_OCC_W = 5;

  typedef enum logic {
    CLR_ON_READ  = 1'b0,
    CLR_ON_EMPTY = 1'b1
  } clr_mode_e;

  typedef enum logic {
    TMR_IDLE = 1'b0,
    TMR_RUN  = 1'b1
  } tmr_state_e;

endpackage

// File: rtl/irq_dly_timer.sv
module irq_dly_timer
  import irq_req_pkg::*;
#(
  parameter int unsigned DLY_W = DEF_DLY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt,
  input  logic [DLY_W-1:0] dly_sel,
  input  logic             key_event,
  input  logic             db_tick,
  output logic             fire
);

  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

  tmr_state_e       state_q, state_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             dly_on;

  assign dly_on = (dly_sel != '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    fire    = 1'b0;
    if (halt || !dly_on) begin
      state_d = TMR_IDLE;
    end else if (key_event) begin
      state_d = TMR_RUN;
      cnt_d   = dly_sel;
      cnt_en  = 1'b1;
    end else if (state_q == TMR_RUN && db_tick) begin
      if (cnt_q == ONE) begin
        fire    = 1'b1;
        state_d = TMR_IDLE;
      end else begin
        cnt_d  = cnt_q - ONE;
        cnt_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TMR_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/irq_lvl_trig.sv
module irq_lvl_trig
  import irq_req_pkg::*;
#(
  parameter int unsigned LVL_W = DEF_LVL_W,
  parameter int unsigned OCC_W = DEF_OCC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] lvl_sel,
  input  logic [OCC_W-1:0] fifo_count,
  output logic             rise
);

  logic above, above_q;

  always_comb begin
    above = (lvl_sel != '0) &&
            (int'(fifo_count) >= 2 * int'(lvl_sel));
    rise  = above && !above_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) above_q <= 1'b0;
    else        above_q <= above;
  end

endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch
  import irq_req_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      drop_all,
  input  logic      set_req,
  input  logic      fifo_rd,
  input  logic      fifo_empty,
  input  clr_mode_e mode,
  output logic      req_q
);

  logic req_d;
  logic clr_cond;

  always_comb begin
    clr_cond = (mode == CLR_ON_READ) ? fifo_rd : fifo_empty;
    req_d    = req_q;
    if (drop_all)      req_d = 1'b0;
    else if (set_req)  req_d = 1'b1;
    else if (clr_cond) req_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen
  import irq_req_pkg::*;
#(
  parameter int unsigned DLY_W = DEF_DLY_W,
  parameter int unsigned LVL_W = DEF_LVL_W,
  parameter int unsigned OCC_W = DEF_OCC_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [DLY_W+LVL_W-1:0] cfg_byte,
  input  logic [OCC_W-1:0]       fifo_count,
  input  logic                   key_event,
  input  logic                   db_tick,
  input  logic                   fifo_rd,
  input  logic                   fifo_empty,
  input  logic                   clr_on_empty,
  input  logic                   gpo_level,
  output logic                   irq_od_en
);

  localparam int unsigned CFG_W = DLY_W + LVL_W;

  logic [1:0]       rst_sync_q;
  logic             rst_sn;
  logic             gpo_mode;
  logic [DLY_W-1:0] dly_sel;
  logic [LVL_W-1:0] lvl_sel;
  logic             t_fire;
  logic             l_rise;
  logic             req_q;
  clr_mode_e        mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  assign gpo_mode = (cfg_byte == CFG_W'(0));
  assign dly_sel  = cfg_byte[DLY_W-1:0];
  assign lvl_sel  = cfg_byte[CFG_W-1:DLY_W];
  assign mode     = clr_on_empty ? CLR_ON_EMPTY : CLR_ON_READ;

  irq_dly_timer #(.DLY_W(DLY_W)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_sn),
    .halt      (gpo_mode),
    .dly_sel   (dly_sel),
    .key_event (key_event),
    .db_tick   (db_tick),
    .fire      (t_fire)
  );

  irq_lvl_trig #(.LVL_W(LVL_W), .OCC_W(OCC_W)) u_lvl (
    .clk        (clk),
    .rst_n      (rst_sn),
    .lvl_sel    (lvl_sel),
    .fifo_count (fifo_count),
    .rise       (l_rise)
  );

  irq_req_latch u_req (
    .clk        (clk),
    .rst_n      (rst_sn),
    .drop_all   (gpo_mode),
    .set_req    (t_fire | l_rise),
    .fifo_rd    (fifo_rd),
    .fifo_empty (fifo_empty),
    .mode       (mode),
    .req_q      (req_q)
  );

  assign irq_od_en = gpo_mode ? ~gpo_level : req_q;

endmodule

// File: rtl/irq_req_gen_chk.sv
module irq_req_gen_chk #(
  parameter int unsigned DLY_W = 5,
  parameter int unsigned LVL_W = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [DLY_W+LVL_W-1:0] cfg_byte,
  input logic                   fifo_rd,
  input logic                   fifo_empty,
  input logic                   clr_on_empty,
  input logic                   gpo_level,
  input logic                   t_fire,
  input logic                   l_rise,
  input logic                   irq_od_en
);

  logic cfg_zero;
  assign cfg_zero = (cfg_byte == '0);

  p_gpo_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_zero |-> (irq_od_en == !gpo_level));

  p_time_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    t_fire |=> (cfg_zero || irq_od_en));

  p_level_fire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (l_rise && !cfg_zero) |=> (cfg_zero || irq_od_en));

  p_read_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_on_empty && fifo_rd && !t_fire && !l_rise && !cfg_zero)
      |=> (cfg_zero || !irq_od_en));

  p_hold_until_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_on_empty && !fifo_empty && irq_od_en && !cfg_zero)
      |=> (cfg_zero || irq_od_en));

  p_rise_has_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_od_en) && !cfg_zero && !$past(cfg_zero))
      |-> $past(t_fire || l_rise));

endmodule

bind irq_req_gen irq_req_gen_chk #(.DLY_W(DLY_W), .LVL_W(LVL_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sn),
  .cfg_byte     (cfg_byte),
  .fifo_rd      (fifo_rd),
  .fifo_empty   (fifo_empty),
  .clr_on_empty (clr_on_empty),
  .gpo_level    (gpo_level),
  .t_fire       (t_fire),
  .l_rise       (l_rise),
  .irq_od_en    (irq_od_en)
);

// File: tb/irq_req_gen_tb.sv
`timescale 1ns/1ps
module irq_req_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] cfg_byte;
  logic [4:0] fifo_count;
  logic       key_event, db_tick, fifo_rd, fifo_empty, clr_on_empty, gpo_level;
  logic       irq_od_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  irq_req_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_byte(cfg_byte), .fifo_count(fifo_count),
    .key_event(key_event), .db_tick(db_tick), .fifo_rd(fifo_rd),
    .fifo_empty(fifo_empty), .clr_on_empty(clr_on_empty),
    .gpo_level(gpo_level), .irq_od_en(irq_od_en)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input logic exp, input string tag);
    checks++;
    if (irq_od_en !== exp) begin
      fails++;
      $display("FAIL %s got=%0b exp=%0b", tag, irq_od_en, exp);
    end
  endtask

  task automatic pulse_key();
    key_event = 1'b1; step(); key_event = 1'b0;
  endtask

  task automatic pulse_tick();
    db_tick = 1'b1; step(); db_tick = 1'b0;
  endtask

  task automatic do_read();
    fifo_rd = 1'b1; step(); fifo_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_byte = 8'h1F; fifo_count = '0; key_event = 0;
    db_tick = 0; fifo_rd = 0; fifo_empty = 1'b1; clr_on_empty = 0; gpo_level = 1'b1;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    chk(1'b0, "R1 reset state");

    // R2 general-purpose output mode
    cfg_byte = 8'h00;
    gpo_level = 1'b0; step(); chk(1'b1, "R2 gpo low");
    gpo_level = 1'b1; step(); chk(1'b0, "R2 gpo high-z");

    // R3 triggers ignored in gpo mode, nothing pending afterwards
    pulse_key(); chk(1'b0, "R3 key ignored");
    for (int i = 0; i < 3; i++) begin pulse_tick(); chk(1'b0, "R3 tick ignored"); end
    fifo_count = 5'd16; step(); chk(1'b0, "R3 level ignored");
    cfg_byte = 8'h1F; step(); chk(1'b0, "R3 no carried request");
    fifo_count = '0; step();

    // R4 R6 R10 delay sweep
    for (int n = 1; n <= 31; n++) begin
      cfg_byte = 8'(n);
      pulse_key();
      for (int t = 1; t < n; t++) pulse_tick();
      chk(1'b0, "R4 before last tick");
      pulse_tick(); chk(1'b1, "R4 fire at tick N");
      do_read(); chk(1'b0, "R10 read clears");
      for (int t = 0; t < 3; t++) pulse_tick();
      chk(1'b0, "R6 stopped after fire");
    end

    // R5 restart on new key event
    cfg_byte = 8'd5;
    pulse_key();
    for (int t = 0; t < 3; t++) pulse_tick();
    pulse_key();
    for (int t = 0; t < 4; t++) pulse_tick();
    chk(1'b0, "R5 restarted count");
    pulse_tick(); chk(1'b1, "R5 fire after restart");
    do_read();
    // R5 same-cycle key and tick: tick not counted
    cfg_byte = 8'd2;
    pulse_key(); pulse_tick();
    key_event = 1'b1; db_tick = 1'b1; step(); key_event = 1'b0; db_tick = 1'b0;
    pulse_tick(); chk(1'b0, "R5 event beats tick");
    pulse_tick(); chk(1'b1, "R5 fire after collision");
    do_read();

    // R7 delay disabled
    cfg_byte = 8'h20;
    pulse_key();
    for (int t = 0; t < 40; t++) pulse_tick();
    chk(1'b0, "R7 delay zero no request");

    // R8 level sweep
    for (int m = 1; m <= 7; m++) begin
      cfg_byte = {3'(m), 5'd0};
      fifo_count = '0; step();
      for (int c = 1; c <= 2 * m; c++) begin
        fifo_count = 5'(c); step();
        chk((c >= 2 * m) ? 1'b1 : 1'b0, "R8 level threshold");
      end
      fifo_count = '0; do_read(); chk(1'b0, "R8 cleared");
    end
    cfg_byte = 8'h01;
    fifo_count = 5'd16; step(); chk(1'b0, "R8 level zero no request");
    fifo_count = '0; step();

    // R9 both triggers
    cfg_byte = {3'd2, 5'd4};
    pulse_key();
    fifo_count = 5'd4; step(); chk(1'b1, "R9 level first");
    fifo_count = '0; do_read(); chk(1'b0, "R9 cleared");
    for (int t = 0; t < 3; t++) pulse_tick();
    chk(1'b0, "R9 timer pending");
    pulse_tick(); chk(1'b1, "R9 timer sets again");
    do_read();
    pulse_key();
    for (int t = 0; t < 4; t++) pulse_tick();
    chk(1'b1, "R9 timer first");
    do_read(); chk(1'b0, "R9 cleared again");
    fifo_count = 5'd4; step(); chk(1'b1, "R9 level sets again");
    fifo_count = '0; do_read();

    // R11 clear on empty mode
    clr_on_empty = 1'b1; fifo_empty = 1'b0;
    cfg_byte = 8'd1;
    pulse_key(); pulse_tick(); chk(1'b1, "R11 asserted");
    do_read(); chk(1'b1, "R11 read does not clear");
    fifo_empty = 1'b1; step(); chk(1'b0, "R11 empty clears");
    clr_on_empty = 1'b0;

    // R12 set beats clear
    cfg_byte = 8'd2;
    pulse_key(); pulse_tick();
    db_tick = 1'b1; fifo_rd = 1'b1; step(); db_tick = 1'b0; fifo_rd = 1'b0;
    chk(1'b1, "R12 set wins");
    do_read(); chk(1'b0, "R12 later read clears");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule